// File: doc/BRIEF.md
# Serial Port Event Router

This block sits beside a serial port's receiver and transmitter. It turns their single-cycle event pulses into interrupt and DMA request signalling. Software controls it through a small 32-bit register bus. One register enables sources when a 1 is written to a bit. A second address clears enables when a 1 is written to a bit, and reads back the same state. A third address holds the pending event flags, and a 1 written to a flag bit acknowledges it.

Each received character goes to one of two places: a receive flag, which drives the interrupt line, or a held DMA request. The choice depends on two DMA enable bits and on whether the frame is a multiprocessor address frame or a data frame. Transmit events are routed in the same way by a transmit DMA enable. Framing, overrun and parity errors set flags of their own. Every flag is ANDed with its enable, and all of them are ORed onto one interrupt output. Two enable bits, the break-detect interrupt enable and the receive-DMA-for-address-frames bit, can only be changed while the compatibility-mode input is high.

Top module: `uart_evt_router`

## Requirements
- R1: After reset, every enable and flag is 0, irqOut, rxDmaReq and txDmaReq are low, and all three registers read 0.
- R2: A write to offset 0x0C sets each enable bit written as 1 and leaves bits written as 0 unchanged. A read of 0x0C returns the enables. Enable bits: 26 framing, 25 overrun, 24 parity, 18 receive-DMA-for-address-frames, 17 receive DMA, 16 transmit DMA, 9 receive, 8 transmit, 1 wakeup, 0 break.
- R3: Every bit outside mask 0x07070303 reads 0 at 0x0C, 0x10 and 0x14, and writes to those bits are ignored. An unmapped offset reads 0, and writes to it change nothing.
- R4: A write to offset 0x10 clears each enable bit written as 1. Bits written as 0 keep their value. A read of 0x10 returns the same value as 0x0C.
- R5: Enable bits 18 and 0 change on a set or clear write only while compatMode is 1. When compatMode is 0 they keep their value.
- R6: With bit 17 clear, each rxFrame pulse sets receive flag bit 9. irqOut then rises on the next cycle only if enable bit 9 is set.
- R7: With bit 17 set and bit 18 clear, an address frame (rxIsAddr=1) sets receive flag 9 and drives irqOut even when enable bit 9 is clear. A data frame raises rxDmaReq instead.
- R8: With bits 17 and 18 both set, every received frame raises rxDmaReq and never sets receive flag 9.
- R9: frameErr, overrunErr and parityErr set flags 26, 25 and 24. Each one drives irqOut only while its enable bit is set.
- R10: Flags are visible at offset 0x14 and stay set until a 1 is written to that bit there. When a new event and a clear of the same flag arrive in the same cycle, the flag stays set.
- R11: A DMA request rises the cycle after its routed event. It stays high until its acknowledge input is seen without a new event in the same cycle.
- R12: A txEvt pulse raises txDmaReq when enable bit 16 is set, and otherwise sets flag 8, gated onto irqOut by enable 8. wakeEvt and brkEvt set flags 1 and 0, which are gated by enables 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| compatMode | input | 1 | Unlocks enable bits 18 and 0 for writes |
| regAddr | input | ADDR_W | Register byte offset, used for both read and write |
| regWrData | input | 32 | Write data |
| regWrEn | input | 1 | Write strobe |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| rxFrame | input | 1 | Pulse: one character received |
| rxIsAddr | input | 1 | Qualifies rxFrame as a multiprocessor address frame |
| txEvt | input | 1 | Pulse: transmitter ready for the next character |
| wakeEvt | input | 1 | Pulse: wakeup detected |
| brkEvt | input | 1 | Pulse: break detected |
| frameErr | input | 1 | Pulse: framing error |
| overrunErr | input | 1 | Pulse: overrun error |
| parityErr | input | 1 | Pulse: parity error |
| rxDmaAck | input | 1 | DMA engine has taken the receive request |
| txDmaAck | input | 1 | DMA engine has taken the transmit request |
| irqOut | output | 1 | OR of every flag ANDed with its enable |
| rxDmaReq | output | 1 | Held receive DMA request |
| txDmaReq | output | 1 | Held transmit DMA request |

## Verification
The assertions check, on every cycle, the properties that need no model: how the DMA request holds and drops, that set writes never clear enables, the compatibility lock on bits 18 and 0, that reserved bits read zero, that data frames in DMA mode reach the request line, and that an enabled pending flag always drives the interrupt. Routing decisions that depend on the full enable state need the bench's reference model, which it steps alongside the design through directed and random traffic. These include address frames interrupting without the receive enable, set-versus-clear priority on flags, and read-back of every register.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

  localparam int DATA_W = 32;

  localparam int BIT_FE      = 26;
  localparam int BIT_OE      = 25;
  localparam int BIT_PE      = 24;
  localparam int BIT_DMA_ALL = 18;
  localparam int BIT_RX_DMA  = 17;
  localparam int BIT_TX_DMA  = 16;
  localparam int BIT_RX      = 9;
  localparam int BIT_TX      = 8;
  localparam int BIT_WAKE    = 1;
  localparam int BIT_BRK     = 0;

  localparam logic [DATA_W-1:0] EN_MASK =
    (DATA_W'(1) << BIT_FE) | (DATA_W'(1) << BIT_OE) | (DATA_W'(1) << BIT_PE) |
    (DATA_W'(1) << BIT_DMA_ALL) | (DATA_W'(1) << BIT_RX_DMA) |
    (DATA_W'(1) << BIT_TX_DMA) | (DATA_W'(1) << BIT_RX) |
    (DATA_W'(1) << BIT_TX) | (DATA_W'(1) << BIT_WAKE) | (DATA_W'(1) << BIT_BRK);

  localparam logic [DATA_W-1:0] COMPAT_MASK =
    (DATA_W'(1) << BIT_DMA_ALL) | (DATA_W'(1) << BIT_BRK);

  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << BIT_FE) | (DATA_W'(1) << BIT_OE) | (DATA_W'(1) << BIT_PE) |
    (DATA_W'(1) << BIT_RX) | (DATA_W'(1) << BIT_TX) |
    (DATA_W'(1) << BIT_WAKE) | (DATA_W'(1) << BIT_BRK);

  typedef struct packed {
    logic              setEn;
    logic              clrEn;
    logic              clrFlag;
    logic [DATA_W-1:0] enBits;
    logic [DATA_W-1:0] flagBits;
    logic              rxToDma;
    logic              rxToFlag;
    logic              txToDma;
    logic              txToFlag;
  } strobe_t;

endpackage

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
  import uart_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 8'h10,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 8'h14
) (
  input  logic              compatMode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  input  logic              rxFrame,
  input  logic              rxIsAddr,
  input  logic              txEvt,
  input  logic              rxDmaOn,
  input  logic              rxDmaAllOn,
  input  logic              txDmaOn,
  output strobe_t           strb
);

  logic [DATA_W-1:0] writable;
  logic              rxGoesDma;

  always_comb begin
    writable = compatMode ? EN_MASK : (EN_MASK & ~COMPAT_MASK);
  end

  // Data frames always go to DMA in DMA mode; address frames only when
  // the all-frames bit is on as well.
  always_comb begin
    rxGoesDma = rxDmaOn && (!rxIsAddr || rxDmaAllOn);
  end

  always_comb begin
    strb          = '0;
    strb.setEn    = regWrEn && (regAddr == SET_OFS);
    strb.clrEn    = regWrEn && (regAddr == CLR_OFS);
    strb.clrFlag  = regWrEn && (regAddr == FLAG_OFS);
    strb.enBits   = regWrData & writable;
    strb.flagBits = regWrData & FLAG_MASK;
    strb.rxToDma  = rxFrame && rxGoesDma;
    strb.rxToFlag = rxFrame && !rxGoesDma;
    strb.txToDma  = txEvt && txDmaOn;
    strb.txToFlag = txEvt && !txDmaOn;
  end

endmodule

// File: rtl/uart_evt_datapath.sv
module uart_evt_datapath
  import uart_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 8'h10,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wakeEvt,
  input  logic              brkEvt,
  input  logic              frameErr,
  input  logic              overrunErr,
  input  logic              parityErr,
  input  logic              rxDmaAck,
  input  logic              txDmaAck,
  output logic [DATA_W-1:0] enState,
  output logic [DATA_W-1:0] flagState,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);

  logic [DATA_W-1:0] evtVec;
  logic [DATA_W-1:0] effEn;

  always_comb begin
    evtVec           = '0;
    evtVec[BIT_FE]   = frameErr;
    evtVec[BIT_OE]   = overrunErr;
    evtVec[BIT_PE]   = parityErr;
    evtVec[BIT_RX]   = strb.rxToFlag;
    evtVec[BIT_TX]   = strb.txToFlag;
    evtVec[BIT_WAKE] = wakeEvt;
    evtVec[BIT_BRK]  = brkEvt;
  end

  // Enable register: set and clear views of the same storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enState <= '0;
    end else if (strb.setEn) begin
      enState <= enState | strb.enBits;
    end else if (strb.clrEn) begin
      enState <= enState & ~strb.enBits;
    end
  end

  // Sticky flags, one flop per implemented bit; a new event beats a clear
  for (genvar b = 0; b < DATA_W; b++) begin : g_flag
    if (FLAG_MASK[b]) begin : g_impl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagState[b] <= 1'b0;
        end else if (evtVec[b]) begin
          flagState[b] <= 1'b1;
        end else if (strb.clrFlag && strb.flagBits[b]) begin
          flagState[b] <= 1'b0;
        end
      end
    end else begin : g_none
      assign flagState[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDmaReq <= 1'b0;
      txDmaReq <= 1'b0;
    end else begin
      if (strb.rxToDma)  rxDmaReq <= 1'b1;
      else if (rxDmaAck) rxDmaReq <= 1'b0;
      if (strb.txToDma)  txDmaReq <= 1'b1;
      else if (txDmaAck) txDmaReq <= 1'b0;
    end
  end

  // Address frames flagged while in DMA mode interrupt without bit 9
  always_comb begin
    effEn         = enState;
    effEn[BIT_RX] = enState[BIT_RX] | enState[BIT_RX_DMA];
    irqOut        = |(flagState & effEn);
  end

  always_comb begin
    if (regAddr == SET_OFS || regAddr == CLR_OFS) begin
      regRdData = enState;
    end else if (regAddr == FLAG_OFS) begin
      regRdData = flagState;
    end else begin
      regRdData = '0;
    end
  end

endmodule

// File: rtl/uart_evt_router.sv
module uart_evt_router
  import uart_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 8'h10,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              compatMode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              regWrEn,
  output logic [31:0]       regRdData,
  input  logic              rxFrame,
  input  logic              rxIsAddr,
  input  logic              txEvt,
  input  logic              wakeEvt,
  input  logic              brkEvt,
  input  logic              frameErr,
  input  logic              overrunErr,
  input  logic              parityErr,
  input  logic              rxDmaAck,
  input  logic              txDmaAck,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);

  strobe_t           strb;
  logic [DATA_W-1:0] enState;
  logic [DATA_W-1:0] flagState;

  uart_evt_ctrl #(
    .ADDR_W(ADDR_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .FLAG_OFS(FLAG_OFS)
  ) ctrl_i (
    .compatMode (compatMode),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regWrEn    (regWrEn),
    .rxFrame    (rxFrame),
    .rxIsAddr   (rxIsAddr),
    .txEvt      (txEvt),
    .rxDmaOn    (enState[BIT_RX_DMA]),
    .rxDmaAllOn (enState[BIT_DMA_ALL]),
    .txDmaOn    (enState[BIT_TX_DMA]),
    .strb       (strb)
  );

  uart_evt_datapath #(
    .ADDR_W(ADDR_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .FLAG_OFS(FLAG_OFS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regAddr    (regAddr),
    .wakeEvt    (wakeEvt),
    .brkEvt     (brkEvt),
    .frameErr   (frameErr),
    .overrunErr (overrunErr),
    .parityErr  (parityErr),
    .rxDmaAck   (rxDmaAck),
    .txDmaAck   (txDmaAck),
    .enState    (enState),
    .flagState  (flagState),
    .regRdData  (regRdData),
    .irqOut     (irqOut),
    .rxDmaReq   (rxDmaReq),
    .txDmaReq   (txDmaReq)
  );

endmodule

// File: rtl/uart_evt_router_chk.sv
module uart_evt_router_chk
  import uart_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h0C
) (
  input logic              clk,
  input logic              rstN,
  input logic              compatMode,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [31:0]       regRdData,
  input logic              rxFrame,
  input logic              rxIsAddr,
  input logic              rxDmaAck,
  input logic              rxDmaReq,
  input logic              irqOut,
  input logic [31:0]       enState,
  input logic [31:0]       flagState
);

  localparam logic [31:0] ERR_MASK =
    (32'd1 << BIT_FE) | (32'd1 << BIT_OE) | (32'd1 << BIT_PE);

  // R11: request holds until acknowledged
  a_r11_dma_hold: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq && !rxDmaAck |=> rxDmaReq);

  // R11: acknowledge without a new frame drops the request
  a_r11_dma_drop: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaAck && !rxFrame |=> !rxDmaReq);

  // R2: a set-register write never clears an enable
  a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == SET_OFS |=> (enState & $past(enState)) == $past(enState));

  // R5: locked bits hold while not in compatibility mode
  a_r5_compat_lock: assert property (@(posedge clk) disable iff (!rstN)
    !compatMode |=> enState[BIT_DMA_ALL] == $past(enState[BIT_DMA_ALL]) &&
                    enState[BIT_BRK] == $past(enState[BIT_BRK]));

  // R3: reserved bits read zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~EN_MASK) == 32'd0);

  // R7: a data frame in DMA mode raises the request
  a_r7_data_to_dma: assert property (@(posedge clk) disable iff (!rstN)
    rxFrame && !rxIsAddr && enState[BIT_RX_DMA] |=> rxDmaReq);

  // R8: with both DMA bits on, a frame cannot set the receive flag
  a_r8_no_rx_flag: assert property (@(posedge clk) disable iff (!rstN)
    !flagState[BIT_RX] && enState[BIT_RX_DMA] && enState[BIT_DMA_ALL]
    |=> !flagState[BIT_RX]);

  // R9: an enabled pending error always reaches the interrupt
  a_r9_err_irq: assert property (@(posedge clk) disable iff (!rstN)
    (flagState & enState & ERR_MASK) != 32'd0 |-> irqOut);

endmodule

bind uart_evt_router uart_evt_router_chk #(.ADDR_W(ADDR_W), .SET_OFS(SET_OFS)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .compatMode (compatMode),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regRdData  (regRdData),
  .rxFrame    (rxFrame),
  .rxIsAddr   (rxIsAddr),
  .rxDmaAck   (rxDmaAck),
  .rxDmaReq   (rxDmaReq),
  .irqOut     (irqOut),
  .enState    (enState),
  .flagState  (flagState)
);

// File: tb/uart_evt_router_tb_top.sv
`timescale 1ns/100ps
module uart_evt_router_tb_top;

  localparam logic [7:0]  A_SET  = 8'h0C;
  localparam logic [7:0]  A_CLR  = 8'h10;
  localparam logic [7:0]  A_FLAG = 8'h14;
  localparam logic [31:0] M_EN   = 32'h0707_0303;
  localparam logic [31:0] M_FLAG = 32'h0700_0303;
  localparam logic [31:0] M_LOCK = 32'h0004_0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic compatMode = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regRdData;
  logic rxFrame = 0, rxIsAddr = 0, txEvt = 0, wakeEvt = 0, brkEvt = 0;
  logic frameErr = 0, overrunErr = 0, parityErr = 0, rxDmaAck = 0, txDmaAck = 0;
  logic irqOut, rxDmaReq, txDmaReq;

  int errors = 0;
  int checks = 0;

  logic [31:0] mEn = '0, mFlag = '0;
  logic mRx = 1'b0, mTx = 1'b0;

  always #2.5 clk = ~clk;

  uart_evt_router dut_i (
    .clk(clk), .rstN(rstN), .compatMode(compatMode), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData),
    .rxFrame(rxFrame), .rxIsAddr(rxIsAddr), .txEvt(txEvt), .wakeEvt(wakeEvt),
    .brkEvt(brkEvt), .frameErr(frameErr), .overrunErr(overrunErr),
    .parityErr(parityErr), .rxDmaAck(rxDmaAck), .txDmaAck(txDmaAck),
    .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expIrq(input logic [31:0] en, input logic [31:0] fl);
    logic [31:0] e;
    e = en;
    e[9] = en[9] | en[17];
    return |(fl & e);
  endfunction

  // Advance the model by one clock using the inputs currently driven
  task automatic modelStep();
    logic [31:0] wm, nEn, nFl;
    logic rxDma, rxFl, txDma, txFl;
    wm = compatMode ? M_EN : (M_EN & ~M_LOCK);
    rxDma = rxFrame && mEn[17] && (!rxIsAddr || mEn[18]);
    rxFl  = rxFrame && !rxDma;
    txDma = txEvt && mEn[16];
    txFl  = txEvt && !mEn[16];
    nEn = mEn;
    if (regWrEn && regAddr == A_SET) nEn = mEn | (regWrData & wm);
    if (regWrEn && regAddr == A_CLR) nEn = mEn & ~(regWrData & wm);
    nFl = mFlag;
    if (regWrEn && regAddr == A_FLAG) nFl = nFl & ~(regWrData & M_FLAG);
    nFl |= {5'b0, frameErr, overrunErr, parityErr, 14'b0, rxFl, txFl, 6'b0, wakeEvt, brkEvt};
    if (rxDma) mRx = 1'b1; else if (rxDmaAck) mRx = 1'b0;
    if (txDma) mTx = 1'b1; else if (txDmaAck) mTx = 1'b0;
    mEn = nEn;
    mFlag = nFl;
  endtask

  task automatic clearInputs();
    regWrEn = 0; rxFrame = 0; rxIsAddr = 0; txEvt = 0; wakeEvt = 0; brkEvt = 0;
    frameErr = 0; overrunErr = 0; parityErr = 0; rxDmaAck = 0; txDmaAck = 0;
  endtask

  // Inputs are driven after a negedge; apply them over one posedge
  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    clearInputs();
  endtask

  task automatic checkOuts(input string tag);
    check(irqOut === expIrq(mEn, mFlag), {tag, " irq"}, 32'(irqOut), 32'(expIrq(mEn, mFlag)));
    check(rxDmaReq === mRx, {tag, " rxReq"}, 32'(rxDmaReq), 32'(mRx));
    check(txDmaReq === mTx, {tag, " txReq"}, 32'(txDmaReq), 32'(mTx));
  endtask

  task automatic checkRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #0.2;
    check(regRdData === exp, tag, regRdData, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    step();
  endtask

  initial begin : watchdog
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkOuts("R1");
    checkRead(A_SET, 32'd0, "R1 set read");
    checkRead(A_FLAG, 32'd0, "R1 flag read");

    // R2, R3: set all, then write zero
    compatMode = 1;
    wr(A_SET, 32'hFFFF_FFFF);
    checkRead(A_SET, M_EN, "R2 set all / R3 reserved");
    wr(A_SET, 32'h0);
    checkRead(A_SET, M_EN, "R2 write zero no effect");
    // R4 clear alias
    wr(A_CLR, 32'h0100_0200);
    checkRead(A_CLR, M_EN & ~32'h0100_0200, "R4 clear alias read");
    checkRead(8'h18, 32'd0, "R3 unmapped read");
    wr(8'h18, 32'hFFFF_FFFF);
    checkRead(A_SET, mEn, "R3 unmapped write");
    // R5 lock
    compatMode = 0;
    wr(A_CLR, 32'hFFFF_FFFF);
    checkRead(A_SET, M_LOCK, "R5 locked bits kept");
    wr(A_SET, 32'h0);
    compatMode = 1;
    wr(A_CLR, M_LOCK);
    checkRead(A_SET, 32'd0, "R5 unlocked clear");

    // R6 no DMA, rx enable off then on
    rxFrame = 1; step();
    checkOuts("R6 rx disabled");
    check(irqOut === 1'b0, "R6 irq gated", 32'(irqOut), 32'd0);
    wr(A_SET, 32'h200);
    check(irqOut === 1'b1, "R6 irq enabled", 32'(irqOut), 32'd1);
    wr(A_FLAG, 32'h200);
    wr(A_CLR, 32'h200);
    checkOuts("R10 flag cleared");

    // R7 DMA mode, all-frames off
    wr(A_SET, 32'h0002_0000);
    rxFrame = 1; rxIsAddr = 1; step();
    check(irqOut === 1'b1, "R7 address frame irq", 32'(irqOut), 32'd1);
    rxFrame = 1; step();
    check(rxDmaReq === 1'b1, "R7 data frame dma", 32'(rxDmaReq), 32'd1);
    // R11 ack with simultaneous frame keeps request
    rxDmaAck = 1; rxFrame = 1; step();
    check(rxDmaReq === 1'b1, "R11 ack+frame", 32'(rxDmaReq), 32'd1);
    rxDmaAck = 1; step();
    check(rxDmaReq === 1'b0, "R11 ack drops", 32'(rxDmaReq), 32'd0);
    // R10 clear and new event same cycle
    regAddr = A_FLAG; regWrData = 32'h200; regWrEn = 1; rxFrame = 1; rxIsAddr = 1; step();
    checkRead(A_FLAG, 32'h200, "R10 set beats clear");
    wr(A_FLAG, M_FLAG);
    // R8 all frames to DMA
    wr(A_SET, 32'h0004_0000);
    rxFrame = 1; rxIsAddr = 1; step();
    checkRead(A_FLAG, 32'd0, "R8 no rx flag");
    check(rxDmaReq === 1'b1, "R8 address to dma", 32'(rxDmaReq), 32'd1);
    rxDmaAck = 1; step();

    // R9 errors
    frameErr = 1; overrunErr = 1; parityErr = 1; step();
    checkRead(A_FLAG, 32'h0700_0000, "R9 error flags");
    check(irqOut === 1'b0, "R9 errors gated", 32'(irqOut), 32'd0);
    wr(A_SET, 32'h0200_0000);
    check(irqOut === 1'b1, "R9 overrun enabled", 32'(irqOut), 32'd1);
    wr(A_FLAG, 32'h0200_0000);
    checkOuts("R9 after clear");

    // R12 tx and wake/brk
    txEvt = 1; step();
    checkOuts("R12 tx flag");
    wr(A_SET, 32'h0001_0000);
    txEvt = 1; step();
    checkOuts("R12 tx dma");
    wakeEvt = 1; brkEvt = 1; step();
    wr(A_SET, 32'h0000_0003);
    checkOuts("R12 wake brk");

    // Random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      compatMode = $urandom_range(0, 1);
      if (r < 3) begin
        case ($urandom_range(0, 3))
          0: regAddr = A_SET;
          1: regAddr = A_CLR;
          2: regAddr = A_FLAG;
          default: regAddr = 8'h18;
        endcase
        regWrData = $urandom();
        regWrEn = 1;
      end
      rxFrame = ($urandom_range(0, 3) == 0);
      rxIsAddr = $urandom_range(0, 1);
      txEvt = ($urandom_range(0, 4) == 0);
      wakeEvt = ($urandom_range(0, 9) == 0);
      brkEvt = ($urandom_range(0, 9) == 0);
      frameErr = ($urandom_range(0, 9) == 0);
      overrunErr = ($urandom_range(0, 9) == 0);
      parityErr = ($urandom_range(0, 9) == 0);
      rxDmaAck = ($urandom_range(0, 2) == 0);
      txDmaAck = ($urandom_range(0, 2) == 0);
      step();
      checkOuts("R12 R7 R8 random");
      if (i % 16 == 0) begin
        checkRead(A_SET, mEn, "R2 random enable read");
        checkRead(A_FLAG, mFlag, "R10 random flag read");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule